// File: doc/BRIEF.md
# Posted Column Command Delay

This block sits on the device side of a double-data-rate memory and models how early column commands are posted. A READ or WRITE may be accepted ahead of its internal issue point; the block holds it for a programmable additive latency before presenting it as an internal issue strobe. From the same command it also derives two latency markers: the cycle in which read data must leave the device, and the cycle in which write data must be taken in. The data path itself is not part of the block.

Timing comes from a small mode register written through a strobe. It holds the additive latency (AL) and the CAS latency (CL). Read latency is AL + CL and write latency is one clock less. An update is refused and an error is flagged when it carries a reserved or out-of-range code, or when it arrives while any command is still in flight. The controller therefore sees every command in flight under one consistent setting.

Commands may arrive on every clock. A single shift pipeline carries them, so order is preserved and the issue strobe and both markers can overlap freely for different commands.

Top module: `posted_cas_delay`

## Requirements
- R1: After reset the active AL is 0 and CL is 3; `iss_vld`, `rdv_vld`, `wrw_vld` and `cfg_err` are low.
- R2: A mode write (`mr_wr` high) with AL code 0..6 and CL code 3..6, made while idle, is used by every command accepted from the next cycle onward. Both fields are plain binary clock counts.
- R3: AL code 7 is reserved. A mode write carrying it changes neither AL nor CL, and `cfg_err` is high for exactly the one cycle after the write.
- R4: A CL code below 3 or above 6 is refused. Neither field changes, and `cfg_err` is high for exactly the one cycle after the write.
- R5: A mode write is refused with a one-cycle `cfg_err` while a command is in flight. In flight means `cmd_vld` is high or a command is still in the pipeline.
- R6: With AL = 0, `iss_vld` rises in the same cycle as `cmd_vld`, carrying that command's type and address.
- R7: With AL = k > 0, `iss_vld` is high exactly k cycles after the command, for one cycle, with its type (`cmd_wr` 1 = WRITE, 0 = READ) and address.
- R8: For a READ, `rdv_vld` is high for one cycle exactly AL + CL cycles after the command, with its address in `rdv_addr`; a WRITE never raises it.
- R9: For a WRITE, `wrw_vld` is high for one cycle exactly AL + CL - 1 cycles after the command, with its address in `wrw_addr`; a READ never raises it.
- R10: Commands on consecutive cycles each produce their own issue strobe and marker at their own latency, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_wr | input | 1 | Mode register write strobe |
| mr_al | input | 3 | Additive latency code (7 reserved) |
| mr_cl | input | 3 | CAS latency code (3..6 legal) |
| cmd_vld | input | 1 | Column command strobe |
| cmd_wr | input | 1 | Command type, 1 = WRITE, 0 = READ |
| cmd_addr | input | ADDR_W | Column address of the command |
| iss_vld | output | 1 | Internal issue strobe |
| iss_wr | output | 1 | Type of the issued command |
| iss_addr | output | ADDR_W | Address of the issued command |
| rdv_vld | output | 1 | Read data due (read latency reached) |
| rdv_addr | output | ADDR_W | Address belonging to `rdv_vld` |
| wrw_vld | output | 1 | Write data window (write latency reached) |
| wrw_addr | output | ADDR_W | Address belonging to `wrw_vld` |
| cfg_err | output | 1 | One-cycle pulse for a refused mode write |

## Verification
The assertions watch, on every cycle, the zero-latency pass-through, the freeze of AL and CL after a reserved, out-of-range or busy-time write, and the rule that an error pulse and each marker always have a cause in the previous cycle. The exact cycle counts of the issue strobe and both markers across several AL and CL settings need the bench's scenarios, and so do the one-cycle width of every pulse, the separation of reads from writes, and the ordering of a back-to-back burst. Those latencies are set by parameters too large to unroll in a property.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int AL_W     = 3;
    localparam int CL_W     = 3;
    localparam int MAX_AL   = 6;
    localparam int MIN_CL   = 3;
    localparam int MAX_CL   = 6;
    localparam int PIPE_LEN = MAX_AL + MAX_CL;

    typedef enum logic {
        KIND_READ  = 1'b0,
        KIND_WRITE = 1'b1
    } cmd_kind_e;

    function automatic logic al_code_ok(input logic [AL_W-1:0] code);
        return int'(code) <= MAX_AL;
    endfunction

    function automatic logic cl_code_ok(input logic [CL_W-1:0] code);
        return (int'(code) >= MIN_CL) && (int'(code) <= MAX_CL);
    endfunction

endpackage

// File: rtl/pcd_mode_reg.sv
module pcd_mode_reg
    import pcd_pkg::*;
#(
    parameter logic [AL_W-1:0] RST_AL = '0,
    parameter logic [CL_W-1:0] RST_CL = 3'd3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mr_wr,
    input  logic [AL_W-1:0] mr_al,
    input  logic [CL_W-1:0] mr_cl,
    input  logic            busy,
    output logic [AL_W-1:0] al_q,
    output logic [CL_W-1:0] cl_q,
    output logic            err_q
);

    logic accept;

    always_comb begin
        accept = !busy && al_code_ok(mr_al) && cl_code_ok(mr_cl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            al_q  <= RST_AL;
            cl_q  <= RST_CL;
            err_q <= 1'b0;
        end else begin
            err_q <= mr_wr && !accept;
            if (mr_wr && accept) begin
                al_q <= mr_al;
                cl_q <= mr_cl;
            end
        end
    end

endmodule

// File: rtl/pcd_shift_line.sv
module pcd_shift_line #(
    parameter int W     = 18,
    parameter int DEPTH = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                taps[g] <= '0;
            end else begin
                if (g == 0) begin
                    taps[g] <= din;
                end else begin
                    taps[g] <= taps[(g == 0) ? 0 : g-1];
                end
            end
        end
    end

endmodule

// File: rtl/pcd_tap_pick.sv
module pcd_tap_pick #(
    parameter int W     = 18,
    parameter int DEPTH = 12,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0][W-1:0] taps,
    input  logic [IDX_W-1:0]        idx,
    output logic [W-1:0]            dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx == IDX_W'(i)) begin
                dout = taps[i];
            end
        end
    end

endmodule

// File: rtl/posted_cas_delay.sv
module posted_cas_delay
    import pcd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mr_wr,
    input  logic [2:0]        mr_al,
    input  logic [2:0]        mr_cl,
    input  logic              cmd_vld,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              iss_vld,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              rdv_vld,
    output logic [ADDR_W-1:0] rdv_addr,
    output logic              wrw_vld,
    output logic [ADDR_W-1:0] wrw_addr,
    output logic              cfg_err
);

    localparam int SLOT_W = ADDR_W + 2;
    localparam int DEPTH  = PIPE_LEN;
    localparam int IDX_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              vld;
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    logic [AL_W-1:0]               act_al;
    logic [CL_W-1:0]               act_cl;
    logic                          busy;
    slot_t                         in_slot;
    logic [DEPTH-1:0][SLOT_W-1:0]  taps;
    logic [IDX_W-1:0]              iss_idx;
    logic [IDX_W-1:0]              rd_idx;
    logic [IDX_W-1:0]              wr_idx;
    slot_t                         iss_tap;
    slot_t                         rd_tap;
    slot_t                         wr_tap;
    slot_t                         iss_slot;

    // in-flight detection: any live stage or a command arriving now
    always_comb begin
        busy = cmd_vld;
        for (int i = 0; i < DEPTH; i++) begin
            busy = busy | taps[i][SLOT_W-1];
        end
    end

    pcd_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .mr_wr (mr_wr),
        .mr_al (mr_al),
        .mr_cl (mr_cl),
        .busy  (busy),
        .al_q  (act_al),
        .cl_q  (act_cl),
        .err_q (cfg_err)
    );

    always_comb begin
        in_slot.vld  = cmd_vld;
        in_slot.kind = cmd_kind_e'(cmd_wr);
        in_slot.addr = cmd_addr;
    end

    pcd_shift_line #(
        .W     (SLOT_W),
        .DEPTH (DEPTH)
    ) u_line (
        .clk  (clk),
        .rst  (rst),
        .din  (in_slot),
        .taps (taps)
    );

    // stage k holds a command k+1 cycles after it arrived
    always_comb begin
        iss_idx = (act_al == '0) ? '0 : IDX_W'(act_al) - IDX_W'(1);
        rd_idx  = IDX_W'(act_al) + IDX_W'(act_cl) - IDX_W'(1);
        wr_idx  = IDX_W'(act_al) + IDX_W'(act_cl) - IDX_W'(2);
    end

    pcd_tap_pick #(.W(SLOT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_iss (
        .taps (taps),
        .idx  (iss_idx),
        .dout (iss_tap)
    );

    pcd_tap_pick #(.W(SLOT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_rd (
        .taps (taps),
        .idx  (rd_idx),
        .dout (rd_tap)
    );

    pcd_tap_pick #(.W(SLOT_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_wr (
        .taps (taps),
        .idx  (wr_idx),
        .dout (wr_tap)
    );

    always_comb begin
        iss_slot = (act_al == '0) ? in_slot : iss_tap;
        iss_vld  = iss_slot.vld;
        iss_wr   = (iss_slot.kind == KIND_WRITE);
        iss_addr = iss_slot.addr;
        rdv_vld  = rd_tap.vld && (rd_tap.kind == KIND_READ);
        rdv_addr = rd_tap.addr;
        wrw_vld  = wr_tap.vld && (wr_tap.kind == KIND_WRITE);
        wrw_addr = wr_tap.addr;
    end

endmodule

// File: rtl/posted_cas_delay_chk.sv
module posted_cas_delay_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mr_wr,
    input logic [2:0]        mr_al,
    input logic [2:0]        mr_cl,
    input logic              cmd_vld,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              iss_vld,
    input logic [ADDR_W-1:0] iss_addr,
    input logic              rdv_vld,
    input logic              wrw_vld,
    input logic              cfg_err,
    input logic [2:0]        act_al,
    input logic [2:0]        act_cl,
    input logic              busy
);

    // R6
    al0_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (act_al == 3'd0) |-> (iss_vld == cmd_vld) && (!cmd_vld || iss_addr == cmd_addr));

    // R3
    rsvd_al_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_wr && mr_al == 3'd7) |=> ($stable(act_al) && $stable(act_cl)));

    // R4
    bad_cl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_wr && (mr_cl < 3'd3 || mr_cl > 3'd6)) |=> ($stable(act_al) && $stable(act_cl)));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mr_wr && busy) |=> ($stable(act_al) && $stable(act_cl)));

    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(mr_wr));

    // R8
    rdv_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rdv_vld |-> $past(busy));

    // R9
    wrw_cause_chk: assert property (@(posedge clk) disable iff (rst)
        wrw_vld |-> $past(busy));

endmodule

bind posted_cas_delay posted_cas_delay_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mr_wr    (mr_wr),
    .mr_al    (mr_al),
    .mr_cl    (mr_cl),
    .cmd_vld  (cmd_vld),
    .cmd_addr (cmd_addr),
    .iss_vld  (iss_vld),
    .iss_addr (iss_addr),
    .rdv_vld  (rdv_vld),
    .wrw_vld  (wrw_vld),
    .cfg_err  (cfg_err),
    .act_al   (act_al),
    .act_cl   (act_cl),
    .busy     (busy)
);

// File: tb/posted_cas_delay_tb.sv
`timescale 1ns/1ps
module posted_cas_delay_tb;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mr_wr = 1'b0;
    logic [2:0]        mr_al = '0;
    logic [2:0]        mr_cl = '0;
    logic              cmd_vld = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              iss_vld;
    logic              iss_wr;
    logic [ADDR_W-1:0] iss_addr;
    logic              rdv_vld;
    logic [ADDR_W-1:0] rdv_addr;
    logic              wrw_vld;
    logic [ADDR_W-1:0] wrw_addr;
    logic              cfg_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    posted_cas_delay #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .mr_wr(mr_wr), .mr_al(mr_al), .mr_cl(mr_cl),
        .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_addr(iss_addr),
        .rdv_vld(rdv_vld), .rdv_addr(rdv_addr),
        .wrw_vld(wrw_vld), .wrw_addr(wrw_addr), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // one command, then watch every output for 16 cycles
    task automatic run_cmd(input bit wr, input logic [ADDR_W-1:0] addr,
                           input int al, input int cl);
        int iss_n = 0, iss_at = -1, rdv_n = 0, rdv_at = -1, wrw_n = 0, wrw_at = -1;
        bit data_ok = 1'b1;
        string iss_req;
        iss_req = (al == 0) ? "R6" : "R7";
        @(negedge clk);
        cmd_vld = 1'b1; cmd_wr = wr; cmd_addr = addr;
        for (int k = 0; k < 16; k++) begin
            if (k > 0) begin
                @(negedge clk);
                if (k == 1) cmd_vld = 1'b0;
            end
            #1;
            if (iss_vld) begin
                iss_n++; iss_at = k;
                if (iss_addr != addr || iss_wr != wr) data_ok = 1'b0;
            end
            if (rdv_vld) begin
                rdv_n++; rdv_at = k;
                if (rdv_addr != addr) data_ok = 1'b0;
            end
            if (wrw_vld) begin
                wrw_n++; wrw_at = k;
                if (wrw_addr != addr) data_ok = 1'b0;
            end
        end
        chk(iss_n == 1, iss_req, iss_n, 1);
        chk(iss_at == al, iss_req, iss_at, al);
        chk(data_ok, "R7 type/address", data_ok, 1);
        if (wr) begin
            chk(wrw_n == 1 && wrw_at == al + cl - 1, "R9", wrw_at, al + cl - 1);
            chk(rdv_n == 0, "R8 no read marker on write", rdv_n, 0);
        end else begin
            chk(rdv_n == 1 && rdv_at == al + cl, "R8", rdv_at, al + cl);
            chk(wrw_n == 0, "R9 no write window on read", wrw_n, 0);
        end
    endtask

    task automatic set_mode(input int al, input int cl, input bit exp_err, input string req);
        @(negedge clk);
        mr_wr = 1'b1; mr_al = 3'(al); mr_cl = 3'(cl);
        @(negedge clk);
        mr_wr = 1'b0;
        #1;
        chk(cfg_err == exp_err, req, cfg_err, exp_err);
        @(negedge clk);
        #1;
        chk(cfg_err == 1'b0, {req, " pulse width"}, cfg_err, 0);
    endtask

    task automatic test_reset;
        #1;
        chk(!iss_vld && !rdv_vld && !wrw_vld && !cfg_err, "R1 outputs idle",
            {iss_vld, rdv_vld, wrw_vld, cfg_err}, 0);
        run_cmd(1'b0, 16'h0011, 0, 3);   // R1 defaults AL=0 CL=3
    endtask

    task automatic test_busy_reject;
        @(negedge clk);
        cmd_vld = 1'b1; cmd_wr = 1'b0; cmd_addr = 16'h0B0B;
        @(negedge clk);
        cmd_vld = 1'b0;
        mr_wr = 1'b1; mr_al = 3'd4; mr_cl = 3'd4;
        @(negedge clk);
        mr_wr = 1'b0;
        #1;
        chk(cfg_err == 1'b1, "R5 busy write refused", cfg_err, 1);
        idle(16);
        run_cmd(1'b0, 16'h0C0C, 1, 3);   // R5 setting kept
    endtask

    task automatic test_burst;
        bit wr_of [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
        int iss_bad = 0, rdv_bad = 0, wrw_bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k < 4) begin
                cmd_vld = 1'b1; cmd_wr = wr_of[k]; cmd_addr = 16'hA000 + 16'(k);
            end else begin
                cmd_vld = 1'b0;
            end
            #1;
            begin
                int i = k - 2;
                bit e = (i >= 0 && i < 4);
                if (iss_vld != e || (e && (iss_addr != 16'hA000 + 16'(i) || iss_wr != wr_of[i])))
                    iss_bad++;
            end
            begin
                int i = k - 6;
                bit e = (i >= 0 && i < 4) && !wr_of[(i >= 0 && i < 4) ? i : 0];
                if (rdv_vld != e || (e && rdv_addr != 16'hA000 + 16'(i))) rdv_bad++;
            end
            begin
                int i = k - 5;
                bit e = (i >= 0 && i < 4) && wr_of[(i >= 0 && i < 4) ? i : 0];
                if (wrw_vld != e || (e && wrw_addr != 16'hA000 + 16'(i))) wrw_bad++;
            end
        end
        chk(iss_bad == 0, "R10 issue order", iss_bad, 0);
        chk(rdv_bad == 0, "R10 read markers", rdv_bad, 0);
        chk(wrw_bad == 0, "R10 write windows", wrw_bad, 0);
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        test_reset();
        set_mode(2, 4, 1'b0, "R2");
        run_cmd(1'b0, 16'h1234, 2, 4);
        run_cmd(1'b1, 16'h4321, 2, 4);
        set_mode(6, 6, 1'b0, "R2");
        run_cmd(1'b0, 16'hFFFF, 6, 6);
        run_cmd(1'b1, 16'h0001, 6, 6);
        set_mode(7, 5, 1'b1, "R3");
        run_cmd(1'b0, 16'h3333, 6, 6);   // R3 AL/CL unchanged
        set_mode(1, 7, 1'b1, "R4");
        set_mode(1, 2, 1'b1, "R4");
        run_cmd(1'b1, 16'h4444, 6, 6);   // R4 unchanged
        set_mode(1, 3, 1'b0, "R2");
        run_cmd(1'b1, 16'h5555, 1, 3);
        test_busy_reject();
        set_mode(0, 5, 1'b0, "R2");
        run_cmd(1'b1, 16'h6666, 0, 5);
        set_mode(2, 4, 1'b0, "R2");
        test_burst();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule